// File: doc/BRIEF.md
# Device Interrupt Queue Trap Generator

This block holds the head and tail pointers of a single per-strand device interrupt queue and turns a non-empty queue into a trap request. Software reaches the two pointers through an alternate-space access port. Each access carries an offset, write data, a write flag and the privilege level the strand is running at. The block checks every access against that privilege level. An access that is not allowed leaves both pointers unchanged and raises an access-exception request with its own trap type.

The queue counts as non-empty whenever head and tail differ. The trap request is level-sensitive and is recomputed every cycle. It is held off in three cases: while the strand runs at hypervisor level, while the interrupt-enable input is low, and for the one cycle after the pipeline acknowledges a trap. Interrupt handlers clear the condition by reading the tail and writing that value into the head. Producers in hypervisor mode append entries by moving the tail.

Top module: `devq_trap_unit`

## Requirements
- R1: After reset both pointers read as zero, `trap_req` is 0 and `exc_req` is 0.
- R2: A permitted read of the head offset (default 0x0C0) or the tail offset (default 0x0C8) returns that pointer on `rd_data` one clock after the access cycle. `rd_data` keeps its value when no access is made.
- R3: While head differs from tail and delivery is allowed, `trap_req` is 1 and `trap_type` is 0x7D. When head equals tail, `trap_req` is 0 and `trap_type` is 0.
- R4: A write to the tail offset at supervisor level (`acc_priv` = 2'b01) leaves the tail unchanged and raises `exc_req` with `exc_type` 0x14.
- R5: A write at hypervisor level (`acc_priv` = 2'b10 or 2'b11) updates either pointer. A write to the head at supervisor level updates the head. The new value is visible from the next clock.
- R6: At hypervisor level `trap_req` stays 0 whatever the pointers hold. It rises once the level drops to supervisor or user while head still differs from tail.
- R7: While `int_enable` is 0, `trap_req` is 0.
- R8: Writing the value read from the tail into the head removes the trap request from the next clock on.
- R9: In the cycle after `trap_ack` is high, `trap_req` is 0. The request returns the cycle after that if the queue is still non-empty.
- R10: Any access to either pointer at user level (`acc_priv` = 2'b00) leaves both pointers unchanged and raises `exc_req` with `exc_type` 0x37. A refused read returns zero on `rd_data`.
- R11: An access to any other offset raises `exc_req` with `exc_type` 0x14 at every privilege level and changes neither pointer.
- R12: `exc_req` is high for exactly one cycle, the cycle after each refused access, and `exc_type` is 0 whenever `exc_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe for one cycle |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W (12) | Offset inside the queue address space |
| acc_wdata | input | DATA_W (64) | Store data |
| acc_priv | input | 2 | Current level: 00 user, 01 supervisor, 1x hypervisor |
| int_enable | input | 1 | Processor-state interrupt enable |
| trap_ack | input | 1 | Pipeline has taken the trap |
| rd_data | output | DATA_W (64) | Load data, one cycle after the access |
| trap_req | output | 1 | Device interrupt trap request |
| trap_type | output | 8 | 0x7D while requesting, else 0 |
| exc_req | output | 1 | Access exception request |
| exc_type | output | 8 | 0x14 invalid space, 0x37 privileged action |

## Verification
The trap request is exercised with head and tail equal, with head moved away from tail at supervisor level, and with tail moved at hypervisor level. Comparing these cases shows that the request depends on the inequality itself and not on which register was written last. The same non-empty queue is then held while only the level, the enable bit and the acknowledge are changed, so each gating term is seen suppressing the request on its own. Writes to the tail, to the head and to unmapped offsets are tried at all three levels. Comparing the results shows which refusal produces which exception type, and confirms by read-back that a refused write leaves both pointers untouched.

// File: rtl/devq_pkg.sv
package devq_pkg;

  localparam int TT_W = 8;

  localparam logic [TT_W-1:0] TT_DEV_INTR   = 8'h7D;
  localparam logic [TT_W-1:0] TT_BAD_SPACE  = 8'h14;
  localparam logic [TT_W-1:0] TT_PRIV_ACT   = 8'h37;

  typedef enum logic [1:0] {
    LVL_USER = 2'b00,
    LVL_SUPV = 2'b01,
    LVL_HYPR = 2'b10,
    LVL_HYP2 = 2'b11
  } level_e;

  typedef struct packed {
    logic            wr_head;
    logic            wr_tail;
    logic            rd_head;
    logic            rd_tail;
    logic            rd_zero;
    logic            fault;
    logic [TT_W-1:0] fault_tt;
  } acc_res_t;

  function automatic logic lvl_is_hyper(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  function automatic logic lvl_is_user(input logic [1:0] lvl);
    return lvl == LVL_USER;
  endfunction

  // Permission decision for one access; priority: unmapped, user, supervisor tail store.
  function automatic acc_res_t judge_access(input logic       valid,
                                            input logic       write,
                                            input logic       hit_head,
                                            input logic       hit_tail,
                                            input logic [1:0] lvl);
    acc_res_t r;
    r = '0;
    if (valid) begin
      if (!(hit_head || hit_tail)) begin
        r.fault    = 1'b1;
        r.fault_tt = TT_BAD_SPACE;
      end else if (lvl_is_user(lvl)) begin
        r.fault    = 1'b1;
        r.fault_tt = TT_PRIV_ACT;
      end else if (write && hit_tail && !lvl_is_hyper(lvl)) begin
        r.fault    = 1'b1;
        r.fault_tt = TT_BAD_SPACE;
      end else begin
        r.wr_head = write && hit_head;
        r.wr_tail = write && hit_tail;
        r.rd_head = !write && hit_head;
        r.rd_tail = !write && hit_tail;
      end
      r.rd_zero = r.fault && !write;
    end
    return r;
  endfunction

  function automatic logic may_deliver(input logic       pending,
                                       input logic [1:0] lvl,
                                       input logic       enable,
                                       input logic       masked);
    return pending && enable && !masked && !lvl_is_hyper(lvl);
  endfunction

endpackage

// File: rtl/devq_access_decode.sv
module devq_access_decode
  import devq_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] HEAD_OFS = 12'h0C0,
  parameter logic [ADDR_W-1:0] TAIL_OFS = 12'h0C8
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lvl,
  output acc_res_t          res
);

  logic hit_head;
  logic hit_tail;

  assign hit_head = (addr == HEAD_OFS);
  assign hit_tail = (addr == TAIL_OFS);

  always_comb begin
    res = judge_access(valid, write, hit_head, hit_tail, lvl);
  end

endmodule

// File: rtl/devq_ptr_regs.sv
module devq_ptr_regs
  import devq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_res_t          res,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head_q,
  output logic [DATA_W-1:0] tail_q,
  output logic [DATA_W-1:0] rd_q
);

  logic [TT_W-1:0] unused_tt;
  logic            unused_fault;
  assign unused_tt    = res.fault_tt;
  assign unused_fault = res.fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      rd_q   <= '0;
    end else begin
      if (res.wr_head) head_q <= wdata;
      if (res.wr_tail) tail_q <= wdata;
      if (res.rd_head)      rd_q <= head_q;
      else if (res.rd_tail) rd_q <= tail_q;
      else if (res.rd_zero) rd_q <= '0;
    end
  end

  // Writes to one pointer never disturb the other (R5)
  p_head_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res.wr_head && !res.wr_tail) |=> $stable(tail_q));
  p_tail_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res.wr_tail && !res.wr_head) |=> $stable(head_q));

endmodule

// File: rtl/devq_trap_ctrl.sv
module devq_trap_ctrl
  import devq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] head_q,
  input  logic [DATA_W-1:0] tail_q,
  input  logic [1:0]        lvl,
  input  logic              int_enable,
  input  logic              trap_ack,
  input  logic              fault,
  input  logic [TT_W-1:0]   fault_tt,
  output logic              trap_req,
  output logic [TT_W-1:0]   trap_type,
  output logic              exc_req,
  output logic [TT_W-1:0]   exc_type
);

  logic q_pending;
  logic ack_mask_q;
  logic deliver_ok;

  assign q_pending  = (head_q != tail_q);
  assign deliver_ok = may_deliver(q_pending, lvl, int_enable, ack_mask_q);
  assign trap_req   = deliver_ok;
  assign trap_type  = deliver_ok ? TT_DEV_INTR : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_mask_q <= 1'b0;
      exc_req    <= 1'b0;
      exc_type   <= '0;
    end else begin
      ack_mask_q <= trap_ack;
      exc_req    <= fault;
      exc_type   <= fault ? fault_tt : '0;
    end
  end

  p_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !q_pending |-> !trap_req);
  p_hyper_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_is_hyper(lvl) |-> !trap_req);
  p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_enable |-> !trap_req);
  p_ack_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ack |=> !trap_req);
  p_exc_type_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> (exc_type == '0));

endmodule

// File: rtl/devq_trap_unit.sv
module devq_trap_unit
  import devq_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 64,
  parameter logic [ADDR_W-1:0] HEAD_OFS = 12'h0C0,
  parameter logic [ADDR_W-1:0] TAIL_OFS = 12'h0C8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [1:0]        acc_priv,
  input  logic              int_enable,
  input  logic              trap_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              trap_req,
  output logic [7:0]        trap_type,
  output logic              exc_req,
  output logic [7:0]        exc_type
);

  acc_res_t          res;
  logic [DATA_W-1:0] head_q;
  logic [DATA_W-1:0] tail_q;
  logic              mapped;

  assign mapped = (acc_addr == HEAD_OFS) || (acc_addr == TAIL_OFS);

  devq_access_decode #(
    .ADDR_W(ADDR_W), .HEAD_OFS(HEAD_OFS), .TAIL_OFS(TAIL_OFS)
  ) u_dec (
    .valid(acc_valid), .write(acc_write), .addr(acc_addr),
    .lvl(acc_priv), .res(res)
  );

  devq_ptr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .res(res), .wdata(acc_wdata),
    .head_q(head_q), .tail_q(tail_q), .rd_q(rd_data)
  );

  devq_trap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .head_q(head_q), .tail_q(tail_q),
    .lvl(acc_priv), .int_enable(int_enable), .trap_ack(trap_ack),
    .fault(res.fault), .fault_tt(res.fault_tt),
    .trap_req(trap_req), .trap_type(trap_type),
    .exc_req(exc_req), .exc_type(exc_type)
  );

  p_sup_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == TAIL_OFS && acc_priv == LVL_SUPV)
    |=> (exc_req && exc_type == TT_BAD_SPACE && $stable(tail_q)));
  p_user_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mapped && acc_priv == LVL_USER)
    |=> (exc_req && exc_type == TT_PRIV_ACT && $stable(head_q) && $stable(tail_q)));
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mapped)
    |=> (exc_req && exc_type == TT_BAD_SPACE && $stable(head_q) && $stable(tail_q)));
  p_exc_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !exc_req);
  p_trap_tt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_type == TT_DEV_INTR));

endmodule

// File: tb/devq_trap_unit_test.sv
module devq_trap_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_HEAD = 12'h0C0;
  localparam logic [11:0] A_TAIL = 12'h0C8;
  localparam logic [11:0] A_BAD  = 12'h0D0;
  localparam logic [1:0]  USR = 2'b00, SUP = 2'b01, HYP = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic [1:0]  acc_priv = 2'b10;
  logic        int_enable = 1'b0;
  logic        trap_ack = 1'b0;
  logic [63:0] rd_data;
  logic        trap_req;
  logic [7:0]  trap_type;
  logic        exc_req;
  logic [7:0]  exc_type;

  int checks = 0;
  int errors = 0;
  logic        got_exc;
  logic [7:0]  got_tt;
  logic [63:0] got_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  devq_trap_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
    .int_enable(int_enable), .trap_ack(trap_ack), .rd_data(rd_data),
    .trap_req(trap_req), .trap_type(trap_type), .exc_req(exc_req),
    .exc_type(exc_type)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, captured at posedge, sampled at next negedge.
  task automatic access(input logic wr, input logic [11:0] a,
                        input logic [63:0] d, input logic [1:0] lvl);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d; acc_priv = lvl;
    @(negedge clk);
    got_exc = exc_req; got_tt = exc_type; got_rd = rd_data;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd_hyp(input logic [11:0] a);
    logic [1:0] keep;
    keep = acc_priv;
    access(1'b0, a, '0, HYP);
    acc_priv = keep;
  endtask

  task automatic t_reset;
    chk(trap_req == 1'b0, "R1 trap_req", trap_req, 0);
    chk(exc_req == 1'b0, "R1 exc_req", exc_req, 0);
    rd_hyp(A_HEAD); chk(got_rd == 0, "R1 head", got_rd, 0);
    rd_hyp(A_TAIL); chk(got_rd == 0, "R1 tail", got_rd, 0);
  endtask

  task automatic t_readback;
    access(1'b1, A_HEAD, 64'h1111_2222_3333_4440, HYP);
    access(1'b1, A_TAIL, 64'h1111_2222_3333_4440, HYP);
    rd_hyp(A_HEAD); chk(got_rd == 64'h1111_2222_3333_4440, "R2 head", got_rd, 64'h1111_2222_3333_4440);
    rd_hyp(A_TAIL); chk(got_rd == 64'h1111_2222_3333_4440, "R2 tail", got_rd, 64'h1111_2222_3333_4440);
    @(negedge clk);
    chk(rd_data == 64'h1111_2222_3333_4440, "R2 hold", rd_data, 64'h1111_2222_3333_4440);
    int_enable = 1'b1; acc_priv = SUP; @(negedge clk);
    chk(trap_req == 1'b0, "R3 equal quiet", trap_req, 0);
    chk(trap_type == 8'h00, "R3 type zero", trap_type, 0);
  endtask

  task automatic t_pending_clear;
    logic [63:0] t;
    access(1'b1, A_HEAD, 64'h1111_2222_3333_4480, SUP);
    chk(trap_req == 1'b1, "R5 sup head write -> R3 pending", trap_req, 1);
    chk(trap_type == 8'h7D, "R3 trap type", trap_type, 8'h7D);
    access(1'b0, A_TAIL, '0, SUP);
    t = got_rd;
    chk(got_exc == 1'b0, "R5 sup tail read allowed", got_exc, 0);
    access(1'b1, A_HEAD, t, SUP);
    chk(trap_req == 1'b0, "R8 cleared", trap_req, 0);
    rd_hyp(A_HEAD); chk(got_rd == t, "R8 head equals tail", got_rd, t);
  endtask

  task automatic t_sup_tail;
    access(1'b1, A_TAIL, 64'hDEAD_0000, SUP);
    chk(got_exc == 1'b1 && got_tt == 8'h14, "R4 exc", {got_exc, got_tt}, {1'b1, 8'h14});
    @(negedge clk);
    chk(exc_req == 1'b0, "R12 one cycle", exc_req, 0);
    rd_hyp(A_TAIL); chk(got_rd == 64'h1111_2222_3333_4440, "R4 tail unchanged", got_rd, 64'h1111_2222_3333_4440);
    chk(trap_req == 1'b0, "R4 no trap", trap_req, 0);
  endtask

  task automatic t_hyper;
    access(1'b1, A_TAIL, 64'h1111_2222_3333_4500, HYP);
    chk(got_exc == 1'b0, "R5 hyp tail write", got_exc, 0);
    repeat (5) @(negedge clk);
    chk(trap_req == 1'b0, "R6 hyper suppress", trap_req, 0);
    acc_priv = SUP; #1;
    chk(trap_req == 1'b1, "R6 delivered at sup", trap_req, 1);
  endtask

  task automatic t_enable_ack;
    int_enable = 1'b0; @(negedge clk);
    chk(trap_req == 1'b0, "R7 disabled", trap_req, 0);
    int_enable = 1'b1; @(negedge clk);
    chk(trap_req == 1'b1, "R7 enabled", trap_req, 1);
    trap_ack = 1'b1; @(negedge clk);
    trap_ack = 1'b0;
    chk(trap_req == 1'b0, "R9 masked", trap_req, 0);
    @(negedge clk);
    chk(trap_req == 1'b1, "R9 returns", trap_req, 1);
  endtask

  task automatic t_user;
    access(1'b1, A_HEAD, 64'h5555, USR);
    chk(got_exc == 1'b1 && got_tt == 8'h37, "R10 user write", {got_exc, got_tt}, {1'b1, 8'h37});
    access(1'b0, A_TAIL, '0, USR);
    chk(got_exc == 1'b1 && got_tt == 8'h37, "R10 user read", {got_exc, got_tt}, {1'b1, 8'h37});
    chk(got_rd == 0, "R10 read zero", got_rd, 0);
    rd_hyp(A_HEAD); chk(got_rd == 64'h1111_2222_3333_4440, "R10 head unchanged", got_rd, 64'h1111_2222_3333_4440);
  endtask

  task automatic t_unmapped;
    access(1'b1, A_BAD, 64'h9, HYP);
    chk(got_exc == 1'b1 && got_tt == 8'h14, "R11 hyp", {got_exc, got_tt}, {1'b1, 8'h14});
    access(1'b0, A_BAD, '0, SUP);
    chk(got_exc == 1'b1 && got_tt == 8'h14, "R11 sup", {got_exc, got_tt}, {1'b1, 8'h14});
    access(1'b1, A_BAD, 64'h9, USR);
    chk(got_exc == 1'b1 && got_tt == 8'h14, "R11 user", {got_exc, got_tt}, {1'b1, 8'h14});
    @(negedge clk);
    chk(exc_req == 1'b0 && exc_type == 0, "R12 idle", {exc_req, exc_type}, 0);
    rd_hyp(A_TAIL); chk(got_rd == 64'h1111_2222_3333_4500, "R11 tail unchanged", got_rd, 64'h1111_2222_3333_4500);
    rd_hyp(A_HEAD); chk(got_rd == 64'h1111_2222_3333_4440, "R11 head unchanged", got_rd, 64'h1111_2222_3333_4440);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_pending_clear();
    t_sup_tail();
    t_hyper();
    t_enable_ack();
    t_user();
    t_unmapped();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule